// File: doc/BRIEF.md
# SHA-512 Message Schedule Stage Two

This block finishes the SHA-512 message expansion for a group of four new schedule words. Upstream logic supplies a 256-bit vector of four partial sums. Each partial sum already holds the older schedule word, the small sigma-zero term and the t-7 word. A second 256-bit vector carries the two most recent schedule words in its upper half. The block adds the small sigma-one of the correct earlier word to each partial sum and returns the four finished words.

The third and fourth outputs need the sigma-one of the first and second outputs. The block therefore evaluates two sigma-plus-add levels in one combinational chain and registers the result once. Transfers on both sides use a valid/ready handshake. The output holds one result and accepts a new operation in the same cycle in which the current one is consumed.

Top module: `sched2_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` is low after that edge. After reset, `in_ready` is high.
- R2: The small sigma-one of a 64-bit word x is ror(x,19) XOR ror(x,61) XOR (x >> 6). Output word 0 equals partial qword 0 plus sigma-one of history qword 2. Output word 1 equals partial qword 1 plus sigma-one of history qword 3.
- R3: Output word 2 equals partial qword 2 plus sigma-one of output word 0. Output word 3 equals partial qword 3 plus sigma-one of output word 1.
- R4: Qword k occupies bits 64k+63 down to 64k of every vector. The output words appear in ascending order, so word 0 is in bits 63:0 and word 3 is in bits 255:192. For a stream built from a message block, the outputs match schedule words 16 to 79.
- R5: Every addition wraps modulo 2^64. For example, partial qword 0 = all ones and history qword 2 = 1<<19 give output word 0 = 64'h0000_0000_0040_2000.
- R6: History qwords 0 and 1 (bits 127:0) have no effect on the result.
- R7: An operation accepted at a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after that same edge.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low. `out_valid` stays high and `out_word` stays stable.
- R9: Whenever `out_ready` is high, `in_ready` is high, so one operation per cycle passes through.
- R10: If a result is consumed and no new operation is accepted at the same edge, `out_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands are valid |
| in_ready | output | 1 | Block can accept operands |
| in_part | input | 256 | Four partial sums, qword 0 in bits 63:0 |
| in_hist | input | 256 | History words; qword 2 and qword 3 are used |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Downstream takes the result |
| out_word | output | 256 | Four finished schedule words, ascending |

## Verification
A wrong rotation or shift amount in either sigma-one level corrupts a finished word at the next valid output. A wrong feed into the second level corrupts only words 2 and 3. The bench compares every group of a full 80-word schedule, so that fault shows up at the first group. A broken handshake register shows as a lost, duplicated or changed result during a backpressure stall, one cycle after the faulty edge.

// File: rtl/sched2_pkg.sv
package sched2_pkg;
  localparam int WORD_W   = 64;
  localparam int LANES    = 4;
  localparam int S1_ROT_A = 19;
  localparam int S1_ROT_B = 61;
  localparam int S1_SHR   = 6;

  // Reference sigma-one for use by the checker.
  function automatic logic [WORD_W-1:0] sig1_ref(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] ra, rb;
    ra = (x >> S1_ROT_A) | (x << (WORD_W - S1_ROT_A));
    rb = (x >> S1_ROT_B) | (x << (WORD_W - S1_ROT_B));
    return ra ^ rb ^ (x >> S1_SHR);
  endfunction
endpackage

// File: rtl/sched2_sigma1.sv
module sched2_sigma1 #(
  parameter int W     = sched2_pkg::WORD_W,
  parameter int ROT_A = sched2_pkg::S1_ROT_A,
  parameter int ROT_B = sched2_pkg::S1_ROT_B,
  parameter int SHR   = sched2_pkg::S1_SHR
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  localparam int RA = ROT_A % W;
  localparam int RB = ROT_B % W;

  logic [2*W-1:0] dbl;
  logic [W-1:0]   rot_a, rot_b;

  always_comb begin
    dbl   = {x, x};
    rot_a = dbl[RA +: W];
    rot_b = dbl[RB +: W];
    y     = rot_a ^ rot_b ^ (x >> SHR);
  end
endmodule

// File: rtl/sched2_lane.sv
module sched2_lane #(
  parameter int W = sched2_pkg::WORD_W
) (
  input  logic [W-1:0] part,
  input  logic [W-1:0] src,
  output logic [W-1:0] word
);
  logic [W-1:0] s1;

  sched2_sigma1 #(.W(W)) u_sig (
    .x(src),
    .y(s1)
  );

  // Sum is truncated to W bits: modulo 2^W.
  assign word = part + s1;
endmodule

// File: rtl/sched2_oreg.sv
module sched2_oreg #(
  parameter int DW = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) out_data <= in_data;
  end
endmodule

// File: rtl/sched2_top.sv
module sched2_top
  import sched2_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = LANES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N*W-1:0] in_part,
  input  logic [N*W-1:0] in_hist,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N*W-1:0] out_word
);
  localparam int HALF = N / 2;
  localparam int VW   = N * W;

  logic [VW-1:0] comb_word;

  // Lower history half is not part of the computation.
  logic unused_hist;
  assign unused_hist = ^in_hist[HALF*W-1:0];

  genvar i;
  generate
    for (i = 0; i < HALF; i++) begin : g_chain
      // First level: sigma-one of the newest history words.
      sched2_lane #(.W(W)) u_lo (
        .part(in_part[i*W +: W]),
        .src (in_hist[(HALF+i)*W +: W]),
        .word(comb_word[i*W +: W])
      );
      // Second level: sigma-one of the first-level results.
      sched2_lane #(.W(W)) u_hi (
        .part(in_part[(HALF+i)*W +: W]),
        .src (comb_word[i*W +: W]),
        .word(comb_word[(HALF+i)*W +: W])
      );
    end
  endgenerate

  sched2_oreg #(.DW(VW)) u_oreg (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (comb_word),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_word)
  );
endmodule

// File: rtl/sched2_chk.sv
module sched2_chk
  import sched2_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int N = LANES
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [N*W-1:0] in_part,
  input logic           out_valid,
  input logic           out_ready,
  input logic [N*W-1:0] out_word
);
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !out_valid);

  a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  a_r9_ready_passes: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  a_r10_drain: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  a_r3_chain_lo: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      out_word[2*W +: W] == $past(in_part[2*W +: W]) + sig1_ref(out_word[0 +: W]));

  a_r3_chain_hi: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=>
      out_word[3*W +: W] == $past(in_part[3*W +: W]) + sig1_ref(out_word[W +: W]));
endmodule

bind sched2_top sched2_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_part(in_part), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word)
);

// File: tb/tb_sched2_top.sv
module tb_sched2_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         in_ready;
  logic [255:0] in_part;
  logic [255:0] in_hist;
  logic         out_valid;
  logic         out_ready;
  logic [255:0] out_word;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [63:0]  w [80];
  logic [255:0] v_part [16];
  logic [255:0] v_hist [16];
  logic [255:0] v_exp  [16];

  always #10 clk = ~clk;

  sched2_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_part(in_part), .in_hist(in_hist), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  function automatic logic [63:0] ror(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction
  function automatic logic [63:0] s0f(input logic [63:0] x);
    return ror(x, 1) ^ ror(x, 8) ^ (x >> 7);
  endfunction
  function automatic logic [63:0] s1f(input logic [63:0] x);
    return ror(x, 19) ^ ror(x, 61) ^ (x >> 6);
  endfunction
  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Full 80-word schedule for a random block, split into stage-two operations.
  task automatic build_block();
    for (int t = 0; t < 16; t++) w[t] = r64();
    for (int t = 16; t < 80; t++)
      w[t] = s1f(w[t-2]) + w[t-7] + s0f(w[t-15]) + w[t-16];
    for (int g = 0; g < 16; g++) begin
      int b = 16 + 4 * g;
      for (int k = 0; k < 4; k++) begin
        v_part[g][64*k +: 64] = w[b-16+k] + s0f(w[b-15+k]) + w[b-7+k];
        v_exp[g][64*k +: 64]  = w[b+k];
      end
      v_hist[g] = {w[b-1], w[b-2], r64(), r64()};
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; in_part = '0; in_hist = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", {255'd0, out_valid}, 256'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", {255'd0, out_valid}, 256'd0);
    check(in_ready == 1'b1, "R1 in_ready after reset", {255'd0, in_ready}, 256'd1);
  endtask

  // R5: wrap of the first-level sum.
  task automatic t_wrap();
    logic [255:0] e;
    in_valid = 1'b1;
    in_part = {192'd0, 64'hFFFF_FFFF_FFFF_FFFF};
    in_hist = {64'd0, 64'd1 << 19, 128'd0};
    @(negedge clk);
    in_valid = 1'b0;
    e = out_word;
    check(out_valid && e[63:0] == 64'h0000_0000_0040_2000, "R5 modulo wrap",
          {192'd0, e[63:0]}, {192'd0, 64'h0000_0000_0040_2000});
    @(negedge clk);
  endtask

  // R6: lower history qwords changed, result unchanged.
  task automatic t_ignore();
    logic [255:0] first;
    build_block();
    in_valid = 1'b1; in_part = v_part[3];
    in_hist = {v_hist[3][255:128], 128'h0};
    @(negedge clk);
    first = out_word;
    in_hist = {v_hist[3][255:128], {4{32'hDEAD_BEEF}}};
    @(negedge clk);
    in_valid = 1'b0;
    check(first == v_exp[3], "R6 result, lower history zero", first, v_exp[3]);
    check(out_word == first, "R6 lower history ignored", out_word, first);
    @(negedge clk);
  endtask

  // R2, R3, R4, R7, R9: back-to-back stream of a full schedule.
  task automatic t_stream(input int blocks);
    for (int b = 0; b < blocks; b++) begin
      build_block();
      for (int g = 0; g < 16; g++) begin
        in_valid = 1'b1; in_part = v_part[g]; in_hist = v_hist[g];
        check(in_ready == 1'b1, "R9 ready with out_ready high", {255'd0, in_ready}, 256'd1);
        @(negedge clk);
        check(out_valid == 1'b1, "R7 valid after accept", {255'd0, out_valid}, 256'd1);
        check(out_word == v_exp[g], "R2 R3 R4 schedule group", out_word, v_exp[g]);
      end
      in_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  // R8 and R10: stall, then resume and drain.
  task automatic t_stall();
    build_block();
    out_ready = 1'b0;
    in_valid = 1'b1; in_part = v_part[5]; in_hist = v_hist[5];
    @(negedge clk);
    in_part = v_part[6]; in_hist = v_hist[6];
    for (int c = 0; c < 3; c++) begin
      check(in_ready == 1'b0, "R8 ready low during stall", {255'd0, in_ready}, 256'd0);
      check(out_valid && out_word == v_exp[5], "R8 result held", out_word, v_exp[5]);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_word == v_exp[6], "R8 next result after stall", out_word, v_exp[6]);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid drops after drain", {255'd0, out_valid}, 256'd0);
  endtask

  initial begin
    t_reset();
    t_wrap();
    t_ignore();
    t_stream(3);
    t_stall();
    // R1 again: reset mid-run clears a pending result.
    out_ready = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset clears result", {255'd0, out_valid}, 256'd0);
    rst = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule